// File: doc/BRIEF.md
# Compressed Active-Cycle Counter

This block measures how many active clock cycles pass between consecutive qualified control-flow records and hands that figure over in a compact floating-point form, ready to be stored next to each record. A cycle counts only while the core is not stalled in a low-power state. When a record is strobed, the accumulated count is encoded into a mantissa and an exponent with a hidden leading bit, and a validity flag is presented alongside it. The count then starts over.

A configuration write or a buffer clear also restarts the count. Such a restart makes the next record's count untrustworthy, so that record carries a cleared validity flag. The raw count stops at its largest value instead of wrapping, so a very long interval reports the largest encodable value.

The default shape is a 12-bit mantissa and a 4-bit exponent. The raw counter is 12 + 2^4 - 1 = 27 bits wide. The encoded value is the mantissa when the exponent is 0. Otherwise it is (4096 + mantissa) shifted left by (exponent - 1).

Top module: `cyc_comp_counter`

## Requirements
- R1: In every cycle where `rec_stb` is 0, the outputs `rec_mant`, `rec_exp` and `rec_valid` are all 0.
- R2: Only cycles with `clk_active` = 1 add to the count. A record reports the active cycles from the most recent restart cycle (inclusive) up to the strobe cycle (exclusive). Reset counts as a restart, and the first cycle after reset release is the first cycle that can be counted.
- R3: A count N below 2^MANT_W is reported with `rec_exp` = 0 and `rec_mant` = N.
- R4: A count N of 2^MANT_W or more is reported with `rec_exp` = p - (MANT_W - 1), where p is the bit position of N's leading one. `rec_mant` is the MANT_W bits directly below that leading one, and any lower bits are dropped.
- R5: The raw count holds at 2^CNT_W - 1 (CNT_W = MANT_W + 2^EXP_W - 1) instead of wrapping. At that value it reports `rec_exp` = 2^EXP_W - 1 and `rec_mant` = all ones.
- R6: A cycle with `rec_stb`, `cfg_wr` or `buf_clr` high restarts the count. That cycle is itself the first cycle of the new interval and is counted if `clk_active` is 1.
- R7: `rec_valid` is 0 on the first record after reset, after a cycle with `cfg_wr`, or after a cycle with `buf_clr`. Once a record has been strobed without such an event, later records carry `rec_valid` = 1.
- R8: When `rec_stb` coincides with `cfg_wr` or `buf_clr`, the record reports the count and validity from before that cycle. Both the count and the validity are then reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_active | input | 1 | High in cycles that are not low-power stalls |
| rec_stb | input | 1 | A qualified record is being written this cycle |
| cfg_wr | input | 1 | The control configuration is being written this cycle |
| buf_clr | input | 1 | A buffer-clear command is issued this cycle |
| rec_mant | output | MANT_W | Encoded count mantissa, valid with `rec_stb` |
| rec_exp | output | EXP_W | Encoded count exponent, valid with `rec_stb` |
| rec_valid | output | 1 | Count-trustworthy flag, valid with `rec_stb` |

## Verification
The assertions assume that `clk_active`, `rec_stb`, `cfg_wr` and `buf_clr` are clean single-cycle levels that are sampled at the rising edge and are stable around it. They also assume that no restart or counting takes place while reset is held. The bench changes every input only at the falling edge and keeps them quiet during reset.

The bench runs a reduced shape with a 4-bit mantissa and a 2-bit exponent, which gives a 7-bit raw counter. This lets the sweeps cover every count from zero through saturation under continuous activity, under gapped activity, and around coincident restart events.

// File: rtl/ccnt_pkg.sv
package ccnt_pkg;

  // Width of the raw counter: hidden bit plus mantissa plus all shift steps.
  function automatic int cnt_width(input int mant_w, input int exp_w);
    return mant_w + (1 << exp_w) - 1;
  endfunction

  // Largest exponent code.
  function automatic int exp_max(input int exp_w);
    return (1 << exp_w) - 1;
  endfunction

endpackage

// File: rtl/ccnt_raw.sv
module ccnt_raw #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] base;
  logic             cnt_en;

  // The clock enable fires on restart or on an active tick.
  always_comb begin
    cnt_en = tick_i | restart_i;
    base   = restart_i ? '0 : cnt_q;
    if (tick_i && (base != CntMax)) begin
      cnt_d = base + 1'b1;
    end else begin
      cnt_d = base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R5: a saturated count holds until a restart.
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CntMax && !restart_i) |=> (cnt_q == CntMax));

  // R6: after a restart the count is 0 or 1.
  p_restart_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q <= CNT_W'(1)));

  // R2: stalled cycles leave the count untouched.
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !restart_i) |=> $stable(cnt_q));

  // R2: an active cycle below saturation adds exactly one.
  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !restart_i && cnt_q != CntMax) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/ccnt_enc.sv
module ccnt_enc #(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 4,
  parameter int CNT_W  = 27
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [MANT_W-1:0] mant_o,
  output logic [EXP_W-1:0]  exp_o
);

  localparam int EMax = ccnt_pkg::exp_max(EXP_W);

  // Priority from low to high: the highest set bit at or above MANT_W wins.
  always_comb begin
    exp_o  = '0;
    mant_o = cnt_i[MANT_W-1:0];
    for (int e = 1; e <= EMax; e++) begin
      if (cnt_i[MANT_W-1+e]) begin
        exp_o  = EXP_W'(e);
        mant_o = cnt_i[MANT_W-2+e -: MANT_W];
      end
    end
  end

endmodule

// File: rtl/ccnt_valid.sv
module ccnt_valid (
  input  logic clk,
  input  logic rst_n,
  input  logic rec_i,
  input  logic wipe_i,
  output logic valid_o
);

  logic valid_q;
  logic valid_d;
  logic valid_en;

  always_comb begin
    valid_en = rec_i | wipe_i;
    valid_d  = wipe_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (valid_en) begin
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

  // R7: a reconfiguration or clear always leaves the flag low.
  p_wipe_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_i |=> !valid_q);

  // R7: a plain record makes the next one trustworthy.
  p_rec_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_i && !wipe_i) |=> valid_q);

endmodule

// File: rtl/cyc_comp_counter.sv
module cyc_comp_counter #(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_active,
  input  logic              rec_stb,
  input  logic              cfg_wr,
  input  logic              buf_clr,
  output logic [MANT_W-1:0] rec_mant,
  output logic [EXP_W-1:0]  rec_exp,
  output logic              rec_valid
);

  localparam int CNT_W = ccnt_pkg::cnt_width(MANT_W, EXP_W);

  logic [CNT_W-1:0]  cnt;
  logic [MANT_W-1:0] enc_mant;
  logic [EXP_W-1:0]  enc_exp;
  logic              valid;
  logic              wipe;
  logic              restart;

  assign wipe    = cfg_wr | buf_clr;
  assign restart = rec_stb | wipe;

  ccnt_raw #(.CNT_W(CNT_W)) raw_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (clk_active),
    .restart_i (restart),
    .cnt_o     (cnt)
  );

  ccnt_enc #(.MANT_W(MANT_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) enc_i (
    .cnt_i  (cnt),
    .mant_o (enc_mant),
    .exp_o  (enc_exp)
  );

  ccnt_valid valid_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rec_i   (rec_stb),
    .wipe_i  (wipe),
    .valid_o (valid)
  );

  // Outputs only carry data alongside a record strobe.
  always_comb begin
    if (rec_stb) begin
      rec_mant  = enc_mant;
      rec_exp   = enc_exp;
      rec_valid = valid;
    end else begin
      rec_mant  = '0;
      rec_exp   = '0;
      rec_valid = 1'b0;
    end
  end

  // R1: quiet outputs between records.
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_stb |-> (rec_mant == '0 && rec_exp == '0 && !rec_valid));

  // R3: a zero exponent means the raw count fits the mantissa exactly.
  p_small_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_stb && rec_exp == '0) |-> (cnt < CNT_W'(1 << MANT_W) && rec_mant == cnt[MANT_W-1:0]));

  // R4: a nonzero exponent points at the leading one of the raw count.
  p_lead_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_stb && rec_exp != '0) |-> (cnt[MANT_W-1+int'(rec_exp)] &&
                                    (cnt >> (MANT_W + int'(rec_exp))) == '0));

  // R8: a record coinciding with a wipe leaves both count and flag reset.
  p_coincide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_stb && wipe) |=> (!valid && cnt <= CNT_W'(1)));

endmodule

// File: tb/cyc_comp_counter_tb.sv
`timescale 1ns/1ps
module cyc_comp_counter_tb_top;

  localparam int M    = 4;
  localparam int E    = 2;
  localparam int CW   = M + (1 << E) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic         clk;
  logic         rst_n;
  logic         clk_active;
  logic         rec_stb;
  logic         cfg_wr;
  logic         buf_clr;
  logic [M-1:0] rec_mant;
  logic [E-1:0] rec_exp;
  logic         rec_valid;

  int n_cmp;
  int n_bad;
  int model_cnt;
  bit model_v;
  bit done;

  cyc_comp_counter #(.MANT_W(M), .EXP_W(E)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_active (clk_active),
    .rec_stb    (rec_stb),
    .cfg_wr     (cfg_wr),
    .buf_clr    (buf_clr),
    .rec_mant   (rec_mant),
    .rec_exp    (rec_exp),
    .rec_valid  (rec_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Arithmetic expectation for R3/R4/R5.
  function automatic void expect_enc(input int n, output int em, output int ee);
    int p;
    if (n < (1 << M)) begin
      ee = 0;
      em = n;
    end else begin
      p = 0;
      for (int b = 0; b < CW; b++) if ((n >> b) & 1) p = b;
      ee = p - (M - 1);
      em = (n >> (p - M)) & ((1 << M) - 1);
    end
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (model count %0d)", req, act, expv, model_cnt);
    end
  endtask

  // One cycle: drive at the falling edge, compare 1 ns later, then advance the model.
  task automatic cyc(input bit a, input bit s, input bit w, input bit c, input string req);
    int em;
    int ee;
    @(negedge clk);
    clk_active = a; rec_stb = s; cfg_wr = w; buf_clr = c;
    #1;
    if (s) begin
      expect_enc(model_cnt, em, ee);
      check({req, " mant"}, int'(rec_mant), em);
      check({req, " exp"}, int'(rec_exp), ee);
      check("R7 valid", int'(rec_valid), int'(model_v));
    end else begin
      check("R1 idle", int'({rec_mant, rec_exp, rec_valid}), 0);
    end
    if (s || w || c) model_cnt = 0;
    if (a && model_cnt < CMAX) model_cnt++;
    if (w || c) model_v = 1'b0;
    else if (s) model_v = 1'b1;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    model_cnt = 0; model_v = 1'b0;
    rst_n = 1'b0; clk_active = 1'b0; rec_stb = 1'b0; cfg_wr = 1'b0; buf_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, then R2/R7: first record after reset is untrusted.
    cyc(0, 0, 0, 0, "R1");
    cyc(1, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, "R2");
    cyc(0, 1, 0, 0, "R2 first after reset");

    // R3/R4/R5: continuous activity sweep through saturation.
    for (int n = 0; n <= CMAX + 10; n++) begin
      for (int k = 0; k < n; k++) cyc(1, 0, 0, 0, "R2");
      cyc(0, 1, 0, 0, (n < (1 << M)) ? "R3" : (n >= CMAX ? "R5" : "R4"));
    end

    // R2: gapped activity, two of every three cycles active.
    for (int n = 0; n <= 160; n += 7) begin
      for (int k = 0; k < n; k++) cyc((k % 3) != 0, 0, 0, 0, "R2");
      cyc(1, 1, 0, 0, "R2 gapped");
    end

    // R6: strobe cycle itself counted when active.
    cyc(1, 1, 0, 0, "R6");
    cyc(0, 1, 0, 0, "R6 strobe counted");

    // R7: config write and clear invalidate the next record.
    for (int k = 0; k < 20; k++) cyc(1, 0, 0, 0, "R2");
    cyc(1, 0, 1, 0, "R6 cfg");
    for (int k = 0; k < 5; k++) cyc(1, 0, 0, 0, "R2");
    cyc(0, 1, 0, 0, "R7 after cfg");
    cyc(0, 1, 0, 0, "R7 second");
    for (int k = 0; k < 9; k++) cyc(1, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, "R6 clear");
    cyc(1, 1, 0, 0, "R7 after clear");

    // R8: strobe coinciding with config write or clear.
    for (int k = 0; k < 40; k++) cyc(1, 0, 0, 0, "R2");
    cyc(1, 1, 0, 0, "R8 setup");
    for (int k = 0; k < 30; k++) cyc(1, 0, 0, 0, "R2");
    cyc(1, 1, 1, 0, "R8 with cfg");
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, "R2");
    cyc(0, 1, 0, 0, "R8 after cfg");
    for (int k = 0; k < 200; k++) cyc(1, 0, 0, 0, "R5");
    cyc(0, 1, 0, 1, "R8 with clear");
    cyc(0, 1, 0, 0, "R8 after clear");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule